// File: doc/BRIEF.md
# Two-Pulse Clutter Canceller

This block removes stationary echoes from a radar receive stream. It sits after range-bin decimation and ahead of Doppler processing. Samples arrive as complex I/Q pairs. Each pair carries a range-bin number, and a start-of-chirp flag marks the first sample of each chirp. For every range bin the block subtracts the sample taken on the previous chirp from the sample on the current chirp. A return that does not change from pulse to pulse therefore cancels to zero, while a moving target leaves a residue. The filter is the two-pulse canceller, y[n] = x[n] − x[n−1], where n counts chirps within one range bin.

The block holds one complex history word per range bin in an internal line memory, addressed by bin number. Each word is read and then overwritten in the same cycle. A single enable input chooses between cancelling and pass-through. The enable is 0 after reset, and the stream then passes unchanged apart from sign extension. The enable is sampled only at the first sample of a chirp, so no chirp is ever partly filtered. The first chirp after cancelling is switched on has no valid history, and every bin of that chirp comes out as zero. The output stream keeps the input's tags and order, two cycles later, and each output lane is one bit wider than the input so that a difference can never overflow.

Top module: `mti_canceller`

## Requirements
- R1: After reset `out_valid` is 0, and the block is in pass-through until the first start-of-chirp sample taken with the enable at 1. A sample that arrives before any start-of-chirp therefore passes unchanged, even with the enable at 1.
- R2: In pass-through, `out_i` and `out_q` equal `in_i` and `in_q`, sign-extended to SAMPLE_W+1 bits.
- R3: `out_valid`, `out_sof` and `out_bin` repeat `in_valid`, `in_sof` and `in_bin` exactly 2 clock cycles later, for back-to-back samples as well as isolated ones, so the bin order is kept.
- R4: When cancelling, `out_i` = current I − I stored for the same bin, and `out_q` = current Q − Q stored for the same bin. The two lanes are computed separately.
- R5: The first chirp that begins with the enable at 1, after a chirp in pass-through (or after reset), outputs 0 on both lanes for every bin.
- R6: Differences use SAMPLE_W+1 bits. With 16-bit inputs, −32768 − 32767 gives −65535 and 32767 − (−32768) gives 65535, with no wrap.
- R7: The enable is sampled only on a sample with `in_valid`=1 and `in_sof`=1. A change in the middle of a chirp has no effect on that chirp's remaining samples and takes effect from the next start-of-chirp.
- R8: Turning cancelling off for a chirp and then on again starts a new zero-output chirp before cancelling resumes.
- R9: History is indexed by bin number, not by position in the chirp, so bins may arrive in any order from chirp to chirp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cancel_en | input | 1 | 1 = cancel, 0 = pass-through; sampled at start-of-chirp |
| in_valid | input | 1 | Input sample present |
| in_sof | input | 1 | Input sample is the first of a chirp |
| in_bin | input | BIN_W | Range-bin number of the input sample |
| in_i | input | SAMPLE_W | Signed in-phase sample |
| in_q | input | SAMPLE_W | Signed quadrature sample |
| out_valid | output | 1 | Output sample present |
| out_sof | output | 1 | Output sample is the first of a chirp |
| out_bin | output | BIN_W | Range-bin number of the output sample |
| out_i | output | SAMPLE_W+1 | Signed in-phase result |
| out_q | output | SAMPLE_W+1 | Signed quadrature result |

## Verification
The bench changes the enable in the middle of a chirp. A design that sampled the enable on every cycle would switch to pass-through part-way through that chirp and return the raw value instead of the difference. It switches cancelling off and on again to show that a zero-output chirp follows. A design that kept stale history through the off period would output a difference there instead. It presents the bins in reversed order on successive chirps, which exposes history kept by arrival position rather than by bin number. It feeds full-scale opposite-sign inputs that a wrapping subtractor would corrupt. It also streams samples back-to-back to pin the two-cycle latency and the tag alignment.

// File: rtl/mti_pkg.sv
package mti_pkg;

    localparam int DEF_SAMPLE_W = 16;
    localparam int DEF_BIN_W    = 6;

    // How the current chirp is treated
    typedef enum logic [1:0] {
        CM_PASS   = 2'd0,   // forward the input unchanged
        CM_PRIME  = 2'd1,   // no history yet: emit zero, fill the line
        CM_CANCEL = 2'd2    // emit current minus stored
    } chirp_mode_e;

    // Mode for a chirp that is starting, given the enable and the mode of the chirp before it
    function automatic chirp_mode_e next_chirp_mode(input logic en, input chirp_mode_e prev);
        chirp_mode_e m;
        if (!en)
            m = CM_PASS;
        else if (prev == CM_PASS)
            m = CM_PRIME;
        else
            m = CM_CANCEL;
        return m;
    endfunction

endpackage

// File: rtl/mti_mode_ctrl.sv
module mti_mode_ctrl
    import mti_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sof_strobe,
    input  logic        cancel_en,
    output chirp_mode_e eff_mode
);

    chirp_mode_e cur_mode;

    // The sample that opens a chirp already uses the new mode
    always_comb begin
        if (sof_strobe)
            eff_mode = next_chirp_mode(cancel_en, cur_mode);
        else
            eff_mode = cur_mode;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cur_mode <= CM_PASS;
        else if (sof_strobe)
            cur_mode <= eff_mode;
    end

    // R7: the chirp mode moves only on a start-of-chirp sample
    a_r7_mode_hold: assert property (@(posedge clk) disable iff (rst)
        !sof_strobe |=> $stable(cur_mode));

    // R5, R8: cancelling is always preceded by a chirp that filled the history
    a_r5_cancel_after_fill: assert property (@(posedge clk) disable iff (rst)
        (cur_mode == CM_CANCEL) |-> ($past(cur_mode) != CM_PASS));

endmodule

// File: rtl/mti_history_ram.sv
module mti_history_ram #(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] line_q [DEPTH];

    // Read-before-write: rdata returns the word stored before this cycle's write
    always_ff @(posedge clk) begin
        rdata <= line_q[addr];
        if (wr_en)
            line_q[addr] <= wdata;
    end

endmodule

// File: rtl/mti_diff_stage.sv
module mti_diff_stage
    import mti_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int BIN_W    = 6
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic                       in_sof,
    input  logic [BIN_W-1:0]           in_bin,
    input  chirp_mode_e                in_mode,
    input  logic signed [SAMPLE_W-1:0] cur_i,
    input  logic signed [SAMPLE_W-1:0] cur_q,
    input  logic signed [SAMPLE_W-1:0] prev_i,
    input  logic signed [SAMPLE_W-1:0] prev_q,
    output logic                       out_valid,
    output logic                       out_sof,
    output logic [BIN_W-1:0]           out_bin,
    output logic signed [SAMPLE_W:0]   out_i,
    output logic signed [SAMPLE_W:0]   out_q
);

    localparam int OUT_W = SAMPLE_W + 1;
    localparam int LANES = 2;

    logic signed [SAMPLE_W-1:0] cur_l  [LANES];
    logic signed [SAMPLE_W-1:0] prev_l [LANES];
    logic signed [OUT_W-1:0]    res_l  [LANES];

    assign cur_l[0]  = cur_i;
    assign cur_l[1]  = cur_q;
    assign prev_l[0] = prev_i;
    assign prev_l[1] = prev_q;

    // One subtractor per lane, widened by a bit so the result never wraps
    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            logic signed [OUT_W-1:0] cur_x;
            logic signed [OUT_W-1:0] prev_x;
            assign cur_x  = {cur_l[k][SAMPLE_W-1], cur_l[k]};
            assign prev_x = {prev_l[k][SAMPLE_W-1], prev_l[k]};
            always_comb begin
                case (in_mode)
                    CM_PASS:   res_l[k] = cur_x;
                    CM_CANCEL: res_l[k] = cur_x - prev_x;
                    default:   res_l[k] = '0;
                endcase
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_bin   <= '0;
            out_i     <= '0;
            out_q     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_sof <= in_sof;
                out_bin <= in_bin;
                out_i   <= res_l[0];
                out_q   <= res_l[1];
            end
        end
    end

endmodule

// File: rtl/mti_canceller.sv
module mti_canceller
    import mti_pkg::*;
#(
    parameter int SAMPLE_W = DEF_SAMPLE_W,
    parameter int BIN_W    = DEF_BIN_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cancel_en,
    input  logic                       in_valid,
    input  logic                       in_sof,
    input  logic [BIN_W-1:0]           in_bin,
    input  logic signed [SAMPLE_W-1:0] in_i,
    input  logic signed [SAMPLE_W-1:0] in_q,
    output logic                       out_valid,
    output logic                       out_sof,
    output logic [BIN_W-1:0]           out_bin,
    output logic signed [SAMPLE_W:0]   out_i,
    output logic signed [SAMPLE_W:0]   out_q
);

    localparam int WORD_W = 2 * SAMPLE_W;

    chirp_mode_e                eff_mode;
    chirp_mode_e                s1_mode;
    logic                       s1_valid;
    logic                       s1_sof;
    logic [BIN_W-1:0]           s1_bin;
    logic signed [SAMPLE_W-1:0] s1_i;
    logic signed [SAMPLE_W-1:0] s1_q;
    logic [WORD_W-1:0]          hist_word;

    mti_mode_ctrl u_mode (
        .clk        (clk),
        .rst        (rst),
        .sof_strobe (in_valid && in_sof),
        .cancel_en  (cancel_en),
        .eff_mode   (eff_mode)
    );

    // History is written on every valid sample, so it is current when cancelling starts
    mti_history_ram #(
        .WORD_W (WORD_W),
        .ADDR_W (BIN_W)
    ) u_line (
        .clk   (clk),
        .wr_en (in_valid),
        .addr  (in_bin),
        .wdata ({in_i, in_q}),
        .rdata (hist_word)
    );

    // Stage 1: hold the sample while the stored word is read
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_sof   <= 1'b0;
            s1_bin   <= '0;
            s1_i     <= '0;
            s1_q     <= '0;
            s1_mode  <= CM_PASS;
        end else begin
            s1_valid <= in_valid;
            s1_sof   <= in_sof;
            s1_bin   <= in_bin;
            s1_i     <= in_i;
            s1_q     <= in_q;
            s1_mode  <= eff_mode;
        end
    end

    mti_diff_stage #(
        .SAMPLE_W (SAMPLE_W),
        .BIN_W    (BIN_W)
    ) u_diff (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (s1_valid),
        .in_sof    (s1_sof),
        .in_bin    (s1_bin),
        .in_mode   (s1_mode),
        .cur_i     (s1_i),
        .cur_q     (s1_q),
        .prev_i    (hist_word[WORD_W-1:SAMPLE_W]),
        .prev_q    (hist_word[SAMPLE_W-1:0]),
        .out_valid (out_valid),
        .out_sof   (out_sof),
        .out_bin   (out_bin),
        .out_i     (out_i),
        .out_q     (out_q)
    );

    // R3: valid follows the input by two cycles
    a_r3_valid_latency: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(in_valid, 2));

    // R3: tags leave in arrival order
    a_r3_bin_order: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_bin == $past(in_bin, 2)) && (out_sof == $past(in_sof, 2)));

    // R5: a chirp without history emits zero on both lanes
    a_r5_prime_zero: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(s1_mode) == CM_PRIME) |-> (out_i == '0 && out_q == '0));

    // R2: pass-through keeps the value
    a_r2_pass_value: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(s1_mode) == CM_PASS) |->
            (out_i == $signed($past(s1_i)) && out_q == $signed($past(s1_q))));

endmodule

// File: tb/sim_mti_canceller.sv
module sim_mti_canceller;
    import mti_pkg::*;

    localparam int SW = 16;
    localparam int BW = 6;
    localparam int NV = 12;

    logic clk = 1'b0;
    logic rst;
    logic cancel_en;
    logic in_valid;
    logic in_sof;
    logic [BW-1:0] in_bin;
    logic signed [SW-1:0] in_i;
    logic signed [SW-1:0] in_q;
    logic out_valid;
    logic out_sof;
    logic [BW-1:0] out_bin;
    logic signed [SW:0] out_i;
    logic signed [SW:0] out_q;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    mti_canceller #(.SAMPLE_W(SW), .BIN_W(BW)) u0 (
        .clk(clk), .rst(rst), .cancel_en(cancel_en),
        .in_valid(in_valid), .in_sof(in_sof), .in_bin(in_bin), .in_i(in_i), .in_q(in_q),
        .out_valid(out_valid), .out_sof(out_sof), .out_bin(out_bin), .out_i(out_i), .out_q(out_q)
    );

    typedef struct packed {
        logic en;
        logic sof;
        int   bin;
        int   si;
        int   sq;
        int   ei;
        int   eq;
    } vec_t;

    // Each row: enable, start-of-chirp, bin, I, Q, expected I, expected Q
    localparam vec_t TBL [NV] = '{
        '{1'b0, 1'b1, 3, 100, -50, 100, -50},              // R2 pass
        '{1'b0, 1'b0, 5, -7, 9, -7, 9},                    // R2 pass
        '{1'b1, 1'b1, 3, 120, -40, 0, 0},                  // R5 fill chirp
        '{1'b1, 1'b0, 5, 3, 4, 0, 0},                      // R5 fill chirp
        '{1'b1, 1'b1, 3, 150, -10, 30, 30},                // R4 cancel
        '{1'b0, 1'b0, 5, 10, -6, 7, -10},                  // R7 mid-chirp off ignored
        '{1'b0, 1'b1, 5, 1, 2, 1, 2},                      // R7 off applies at sof
        '{1'b0, 1'b0, 3, 5, 6, 5, 6},                      // R7 pass
        '{1'b1, 1'b1, 3, 9, 9, 0, 0},                      // R8 refill chirp
        '{1'b1, 1'b0, 5, 32767, -32768, 0, 0},             // R8 refill chirp
        '{1'b1, 1'b1, 5, -32768, 32767, -65535, 65535},    // R6 full width
        '{1'b1, 1'b0, 3, 0, 0, -9, -9}                     // R9 bins reversed
    };
    localparam string TAG [NV] = '{"R2", "R2", "R5", "R5", "R4", "R7",
                                   "R7", "R7", "R8", "R8", "R6", "R9"};

    task automatic check_int(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic en, input logic sof, input int bin, input int si, input int sq);
        cancel_en = en;
        in_valid  = 1'b1;
        in_sof    = sof;
        in_bin    = bin[BW-1:0];
        in_i      = si[SW-1:0];
        in_q      = sq[SW-1:0];
    endtask

    task automatic idle();
        in_valid = 1'b0;
        in_sof   = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        cancel_en = 1'b0;
        in_valid = 1'b0;
        in_sof = 1'b0;
        in_bin = '0;
        in_i = '0;
        in_q = '0;
        repeat (4) @(negedge clk);
        check_int("R1 valid in reset", int'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check_int("R1 valid after reset", int'(out_valid), 0);

        // R1: enable high but no chirp start yet, so pass-through
        drive(1'b1, 1'b0, 7, 44, -33);
        @(negedge clk); idle();
        @(negedge clk);
        check_int("R1 pre-sof valid", int'(out_valid), 1);
        check_int("R1 pre-sof I", int'(out_i), 44);
        check_int("R1 pre-sof Q", int'(out_q), -33);

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            drive(TBL[k].en, TBL[k].sof, TBL[k].bin, TBL[k].si, TBL[k].sq);
            @(negedge clk); idle();
            @(negedge clk);
            check_int({TAG[k], " I"}, int'(out_i), TBL[k].ei);
            check_int({TAG[k], " Q"}, int'(out_q), TBL[k].eq);
            check_int({TAG[k], " R3 tag"}, out_valid ? int'(out_bin) * 2 + int'(out_sof) : -1,
                      TBL[k].bin * 2 + int'(TBL[k].sof));
        end

        // R3: back-to-back stream, each result two cycles after its sample
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            if (c >= 2) begin
                check_int("R3 stream valid", int'(out_valid), 1);
                check_int("R3 stream bin", int'(out_bin), 10 + c - 2);
                check_int("R3 stream I", int'(out_i), 10 * (c - 1));
                check_int("R3 stream sof", int'(out_sof), (c == 2) ? 1 : 0);
            end
            if (c < 3) drive(1'b0, c == 0, 10 + c, 10 * (c + 1), 0);
            else idle();
        end
        @(negedge clk);
        check_int("R3 stream drained", int'(out_valid), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule